// File: doc/BRIEF.md
# Hyperblock Output Commit Controller

This block gathers the register results of speculatively executing hyperblocks and releases them to the register file only when a whole block is complete. When a block is mapped it is given a context and a number of distinct register outputs it must deliver. Results then arrive from the execution array. Each result is tagged with its context, destination register, static program-order index and a predicate. Results from disabled predicate paths do not count.

Four contexts live in a ring. Only the oldest context may commit. A branch exit event can lower the visible index window and replace the expected count, which discards results past the exit. A misprediction flag on that event also frees every younger context. A complete block drains one register write per cycle, ordered by static index, and then its context is released.

Top module: `hb_commit_ctrl`

## Requirements
- R1: After reset no register write is issued, `alloc_ready_o` is 1 and `alloc_id_o` is 0.
- R2: Allocation hands out context ids in ring order 0,1,2,3,0. `alloc_ready_o` is 0 while all four contexts are in use, and an allocation request made then changes nothing.
- R3: A result is ignored when its predicate is 0, when its context is not in flight, or when its context has already started committing.
- R4: The oldest context commits once the number of distinct registers it holds equals its expected count. Its first write appears in the cycle after the count is reached, and the writes follow at one per cycle on consecutive cycles.
- R5: Within a block, writes leave in ascending static index, and entries with equal index leave in ascending register number.
- R6: Blocks commit in allocation order. A complete younger block issues no write before every older block has drained. After its last write, a context is freed one cycle later.
- R7: A second result for a register already held replaces the held value only when its static index is higher. It never changes the held count.
- R8: An exit event on an in-flight context sets a new exit index and a new expected count. It discards held results whose index is above the exit index. It also rejects later results whose index is above it, and a result for the same context in the same cycle.
- R9: An exit event with the mispredict flag frees all contexts younger than its own, and the next allocation id becomes its context plus one. An allocation in the same cycle is discarded.
- R10: A context holds at most 16 distinct registers. A further new register is dropped while the context is full.
- R11: A block with expected count zero commits with no writes. Its context is freed two cycles after it becomes oldest.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| alloc_valid_i | input | 1 | Request a new block context |
| alloc_count_i | input | 5 | Expected number of distinct outputs |
| alloc_ready_o | output | 1 | A free context exists |
| alloc_id_o | output | 2 | Context id the next allocation receives |
| out_valid_i | input | 1 | Result delivery |
| out_ctx_i | input | 2 | Context of the result |
| out_pred_i | input | 1 | Result is from the enabled predicate path |
| out_reg_i | input | 5 | Destination register |
| out_idx_i | input | 6 | Static program-order index |
| out_data_i | input | 16 | Result value |
| exit_valid_i | input | 1 | Branch exit event |
| exit_ctx_i | input | 2 | Context of the exiting branch |
| exit_idx_i | input | 6 | Static index of the exiting branch |
| exit_count_i | input | 5 | Corrected expected count |
| exit_mispred_i | input | 1 | Flush all younger contexts |
| rf_we_o | output | 1 | Register file write enable |
| rf_addr_o | output | 5 | Register file write address |
| rf_data_o | output | 16 | Register file write data |

## Verification
The hardest states to reach are the overlaps. One is a younger block completing while an older one still waits. Others are an exit arriving in the same cycle as a result or an allocation, and a context being refilled past its capacity. Directed sequences build each overlap on purpose: complete the second context first, pair an exit with a result or an allocation in a single cycle, and request more outputs than the buffer can hold before an exit lowers the count. A long random phase then mixes allocations, duplicate-heavy results on a narrow register range, and exits with and without mispredicts. A behavioural model checks every cycle of that phase.

// File: rtl/hb_pkg.sv
package hb_pkg;
  // distance of slot a from ring head h
  function automatic int ring_dist(input int a, input int h, input int n);
    return (a + n - h) % n;
  endfunction
endpackage

// File: rtl/hb_ctx_buf.sv
module hb_ctx_buf #(
  parameter int SLOTS  = 16,
  parameter int REG_W  = 5,
  parameter int IDX_W  = 6,
  parameter int DATA_W = 16,
  parameter int CNT_W  = 5,
  parameter int SLOT_W = 4
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic                              alloc_i,
  input  logic [CNT_W-1:0]                  alloc_cnt_i,
  input  logic                              flush_i,
  input  logic                              out_en_i,
  input  logic [REG_W-1:0]                  out_reg_i,
  input  logic [IDX_W-1:0]                  out_idx_i,
  input  logic [DATA_W-1:0]                 out_data_i,
  input  logic                              exit_en_i,
  input  logic [IDX_W-1:0]                  exit_idx_i,
  input  logic [CNT_W-1:0]                  exit_cnt_i,
  input  logic                              pop_en_i,
  input  logic [SLOT_W-1:0]                 pop_slot_i,
  output logic [SLOTS-1:0]                  vld_o,
  output logic [SLOTS-1:0][REG_W-1:0]       reg_o,
  output logic [SLOTS-1:0][IDX_W-1:0]       idx_o,
  output logic [SLOTS-1:0][DATA_W-1:0]      data_o,
  output logic [CNT_W-1:0]                  expect_o,
  output logic [CNT_W-1:0]                  count_o
);
  logic [SLOTS-1:0]             vld_q;
  logic [SLOTS-1:0][REG_W-1:0]  reg_q;
  logic [SLOTS-1:0][IDX_W-1:0]  idx_q;
  logic [SLOTS-1:0][DATA_W-1:0] data_q;
  logic [IDX_W-1:0]             exit_idx_q;
  logic [CNT_W-1:0]             expect_q;

  logic              hit_any, free_any, in_window, beyond;
  logic [SLOT_W-1:0] hit_slot, free_slot;
  logic [CNT_W-1:0]  cnt;

  assign in_window = out_idx_i <= exit_idx_q;

  always_comb begin
    hit_any   = 1'b0;
    hit_slot  = '0;
    free_any  = 1'b0;
    free_slot = '0;
    cnt       = '0;
    beyond    = 1'b0;
    for (int i = 0; i < SLOTS; i++) begin
      if (vld_q[i] && reg_q[i] == out_reg_i) begin
        hit_any  = 1'b1;
        hit_slot = SLOT_W'(i);
      end
      cnt = cnt + CNT_W'(vld_q[i]);
      if (vld_q[i] && idx_q[i] > exit_idx_q) beyond = 1'b1;
    end
    for (int i = SLOTS - 1; i >= 0; i--) begin
      if (!vld_q[i]) begin
        free_any  = 1'b1;
        free_slot = SLOT_W'(i);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q      <= '0;
      reg_q      <= '0;
      idx_q      <= '0;
      data_q     <= '0;
      exit_idx_q <= '1;
      expect_q   <= '0;
    end else if (alloc_i) begin
      vld_q      <= '0;
      expect_q   <= alloc_cnt_i;
      exit_idx_q <= '1;
    end else if (flush_i) begin
      vld_q <= '0;
    end else begin
      if (exit_en_i) begin
        exit_idx_q <= exit_idx_i;
        expect_q   <= exit_cnt_i;
        for (int i = 0; i < SLOTS; i++)
          if (idx_q[i] > exit_idx_i) vld_q[i] <= 1'b0;
      end
      if (out_en_i && in_window) begin
        if (hit_any) begin
          if (out_idx_i > idx_q[hit_slot]) begin
            idx_q[hit_slot]  <= out_idx_i;
            data_q[hit_slot] <= out_data_i;
          end
        end else if (free_any) begin
          vld_q[free_slot]  <= 1'b1;
          reg_q[free_slot]  <= out_reg_i;
          idx_q[free_slot]  <= out_idx_i;
          data_q[free_slot] <= out_data_i;
        end
      end
      if (pop_en_i) vld_q[pop_slot_i] <= 1'b0;
    end
  end

  assign vld_o    = vld_q;
  assign reg_o    = reg_q;
  assign idx_o    = idx_q;
  assign data_o   = data_q;
  assign expect_o = expect_q;
  assign count_o  = cnt;

  logic quiet;
  assign quiet = !alloc_i && !flush_i && !exit_en_i && !pop_en_i;

  a_r8_exit_purge: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exit_en_i && !alloc_i && !flush_i |=> !beyond);
  a_r7_dup_count: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_en_i && in_window && hit_any && quiet |=> count_o == $past(count_o));
  a_r10_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_en_i && !hit_any && !free_any && quiet |=> count_o == $past(count_o));
endmodule

// File: rtl/hb_drain_pick.sv
module hb_drain_pick #(
  parameter int SLOTS  = 16,
  parameter int REG_W  = 5,
  parameter int IDX_W  = 6,
  parameter int SLOT_W = 4
) (
  input  logic [SLOTS-1:0]            vld_i,
  input  logic [SLOTS-1:0][REG_W-1:0] reg_i,
  input  logic [SLOTS-1:0][IDX_W-1:0] idx_i,
  output logic                        any_o,
  output logic [SLOT_W-1:0]           sel_o
);
  localparam int KEY_W = IDX_W + REG_W;
  logic [KEY_W-1:0] best;

  // lowest {index, register} key wins
  always_comb begin
    any_o = 1'b0;
    sel_o = '0;
    best  = '1;
    for (int i = 0; i < SLOTS; i++) begin
      if (vld_i[i] && (!any_o || {idx_i[i], reg_i[i]} < best)) begin
        any_o = 1'b1;
        sel_o = SLOT_W'(i);
        best  = {idx_i[i], reg_i[i]};
      end
    end
  end
endmodule

// File: rtl/hb_commit_ctrl.sv
module hb_commit_ctrl #(
  parameter int NCTX   = 4,
  parameter int SLOTS  = 16,
  parameter int REG_W  = 5,
  parameter int IDX_W  = 6,
  parameter int DATA_W = 16,
  localparam int CTX_W  = $clog2(NCTX),
  localparam int SLOT_W = $clog2(SLOTS),
  localparam int CNT_W  = $clog2(SLOTS + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              alloc_valid_i,
  input  logic [CNT_W-1:0]  alloc_count_i,
  output logic              alloc_ready_o,
  output logic [CTX_W-1:0]  alloc_id_o,
  input  logic              out_valid_i,
  input  logic [CTX_W-1:0]  out_ctx_i,
  input  logic              out_pred_i,
  input  logic [REG_W-1:0]  out_reg_i,
  input  logic [IDX_W-1:0]  out_idx_i,
  input  logic [DATA_W-1:0] out_data_i,
  input  logic              exit_valid_i,
  input  logic [CTX_W-1:0]  exit_ctx_i,
  input  logic [IDX_W-1:0]  exit_idx_i,
  input  logic [CNT_W-1:0]  exit_count_i,
  input  logic              exit_mispred_i,
  output logic              rf_we_o,
  output logic [REG_W-1:0]  rf_addr_o,
  output logic [DATA_W-1:0] rf_data_o
);
  logic [NCTX-1:0]  ctx_vld_q;
  logic [CTX_W-1:0] head_q, tail_q;
  logic             drain_q;

  logic [NCTX-1:0][SLOTS-1:0]             b_vld;
  logic [NCTX-1:0][SLOTS-1:0][REG_W-1:0]  b_reg;
  logic [NCTX-1:0][SLOTS-1:0][IDX_W-1:0]  b_idx;
  logic [NCTX-1:0][SLOTS-1:0][DATA_W-1:0] b_data;
  logic [NCTX-1:0][CNT_W-1:0]             b_exp, b_cnt;
  logic [NCTX-1:0]                        younger;

  logic go, head_closed, exit_acc, flush, alloc_acc, out_acc, any, free;
  logic [SLOT_W-1:0] sel;
  logic [IDX_W-1:0]  sel_idx;

  assign go          = ctx_vld_q[head_q] && !drain_q && b_cnt[head_q] == b_exp[head_q];
  assign head_closed = drain_q || go;
  assign exit_acc    = exit_valid_i && ctx_vld_q[exit_ctx_i]
                       && !(exit_ctx_i == head_q && head_closed);
  assign flush       = exit_acc && exit_mispred_i;
  assign alloc_ready_o = !(&ctx_vld_q);
  assign alloc_acc   = alloc_valid_i && alloc_ready_o && !flush;
  assign out_acc     = out_valid_i && out_pred_i && ctx_vld_q[out_ctx_i]
                       && !(out_ctx_i == head_q && head_closed)
                       && !(exit_acc && exit_ctx_i == out_ctx_i);
  assign alloc_id_o  = tail_q;

  for (genvar c = 0; c < NCTX; c++) begin : g_ctx
    assign younger[c] = flush && (hb_pkg::ring_dist(c, int'(head_q), NCTX)
                        > hb_pkg::ring_dist(int'(exit_ctx_i), int'(head_q), NCTX));
    hb_ctx_buf #(
      .SLOTS(SLOTS), .REG_W(REG_W), .IDX_W(IDX_W), .DATA_W(DATA_W),
      .CNT_W(CNT_W), .SLOT_W(SLOT_W)
    ) u_buf (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .alloc_i     (alloc_acc && tail_q == CTX_W'(c)),
      .alloc_cnt_i (alloc_count_i),
      .flush_i     (younger[c]),
      .out_en_i    (out_acc && out_ctx_i == CTX_W'(c)),
      .out_reg_i   (out_reg_i),
      .out_idx_i   (out_idx_i),
      .out_data_i  (out_data_i),
      .exit_en_i   (exit_acc && exit_ctx_i == CTX_W'(c)),
      .exit_idx_i  (exit_idx_i),
      .exit_cnt_i  (exit_count_i),
      .pop_en_i    (rf_we_o && head_q == CTX_W'(c)),
      .pop_slot_i  (sel),
      .vld_o       (b_vld[c]),
      .reg_o       (b_reg[c]),
      .idx_o       (b_idx[c]),
      .data_o      (b_data[c]),
      .expect_o    (b_exp[c]),
      .count_o     (b_cnt[c])
    );
  end

  hb_drain_pick #(
    .SLOTS(SLOTS), .REG_W(REG_W), .IDX_W(IDX_W), .SLOT_W(SLOT_W)
  ) u_pick (
    .vld_i (b_vld[head_q]),
    .reg_i (b_reg[head_q]),
    .idx_i (b_idx[head_q]),
    .any_o (any),
    .sel_o (sel)
  );

  assign rf_we_o   = drain_q && any;
  assign free      = drain_q && !any;
  assign rf_addr_o = b_reg[head_q][sel];
  assign rf_data_o = b_data[head_q][sel];
  assign sel_idx   = b_idx[head_q][sel];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctx_vld_q <= '0;
      head_q    <= '0;
      tail_q    <= '0;
      drain_q   <= 1'b0;
    end else begin
      for (int c = 0; c < NCTX; c++) begin
        if (younger[c]) ctx_vld_q[c] <= 1'b0;
        if (free && head_q == CTX_W'(c)) ctx_vld_q[c] <= 1'b0;
        if (alloc_acc && tail_q == CTX_W'(c)) ctx_vld_q[c] <= 1'b1;
      end
      if (free) head_q <= head_q + 1'b1;
      if (flush) tail_q <= exit_ctx_i + 1'b1;
      else if (alloc_acc) tail_q <= tail_q + 1'b1;
      if (free) drain_q <= 1'b0;
      else if (go) drain_q <= 1'b1;
    end
  end

  a_r6_head_after_drain: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (head_q != $past(head_q)) |-> $past(drain_q));
  a_r5_drain_order: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rf_we_o && $past(rf_we_o) |-> {sel_idx, rf_addr_o} > $past({sel_idx, rf_addr_o}));
  a_r2_full_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alloc_valid_i && !alloc_ready_o && !flush |=> tail_q == $past(tail_q));
  a_r9_flush_tail: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush |=> alloc_id_o == CTX_W'($past(exit_ctx_i) + 1'b1));
endmodule

// File: tb/tb_hb_commit_ctrl.sv
module tb_hb_commit_ctrl;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #4 clk = ~clk;

  logic        alloc_valid = 0;
  logic [4:0]  alloc_count = 0;
  logic        alloc_ready;
  logic [1:0]  alloc_id;
  logic        out_valid = 0, out_pred = 0;
  logic [1:0]  out_ctx = 0;
  logic [4:0]  out_reg = 0;
  logic [5:0]  out_idx = 0;
  logic [15:0] out_data = 0;
  logic        exit_valid = 0, exit_mis = 0;
  logic [1:0]  exit_ctx = 0;
  logic [5:0]  exit_idx = 0;
  logic [4:0]  exit_count = 0;
  logic        rf_we;
  logic [4:0]  rf_addr;
  logic [15:0] rf_data;

  hb_commit_ctrl dut (
    .clk_i(clk), .rst_ni(rst_ni),
    .alloc_valid_i(alloc_valid), .alloc_count_i(alloc_count),
    .alloc_ready_o(alloc_ready), .alloc_id_o(alloc_id),
    .out_valid_i(out_valid), .out_ctx_i(out_ctx), .out_pred_i(out_pred),
    .out_reg_i(out_reg), .out_idx_i(out_idx), .out_data_i(out_data),
    .exit_valid_i(exit_valid), .exit_ctx_i(exit_ctx), .exit_idx_i(exit_idx),
    .exit_count_i(exit_count), .exit_mispred_i(exit_mis),
    .rf_we_o(rf_we), .rf_addr_o(rf_addr), .rf_data_o(rf_data)
  );

  int compared = 0, mismatched = 0;

  // behavioural reference
  bit m_valid [4];
  int m_exp [4], m_eidx [4];
  bit m_has [4][32];
  int m_ridx [4][32], m_rdat [4][32];
  int m_head = 0, m_tail = 0;
  bit m_drain = 0;

  function automatic int mcount(int c);
    int n = 0;
    for (int r = 0; r < 32; r++) n += int'(m_has[c][r]);
    return n;
  endfunction

  function automatic int mmin(int c); // -1 when empty
    int best = -1, bk = 0;
    for (int r = 0; r < 32; r++)
      if (m_has[c][r] && (best < 0 || m_ridx[c][r] * 32 + r < bk)) begin
        best = r; bk = m_ridx[c][r] * 32 + r;
      end
    return best;
  endfunction

  task automatic model_step();
    int h = m_head, oc = int'(out_ctx), ec = int'(exit_ctx);
    bit go, hc, e_acc, fl, a_acc, o_acc, full;
    full = m_valid[0] && m_valid[1] && m_valid[2] && m_valid[3];
    go = m_valid[h] && !m_drain && mcount(h) == m_exp[h];
    hc = m_drain || go;
    e_acc = exit_valid && m_valid[ec] && !(ec == h && hc);
    fl = e_acc && exit_mis;
    a_acc = alloc_valid && !full && !fl;
    o_acc = out_valid && out_pred && m_valid[oc] && !(oc == h && hc)
            && !(e_acc && ec == oc) && int'(out_idx) <= m_eidx[oc];
    if (o_acc) begin
      int r = int'(out_reg);
      if (m_has[oc][r]) begin
        if (int'(out_idx) > m_ridx[oc][r]) begin
          m_ridx[oc][r] = int'(out_idx); m_rdat[oc][r] = int'(out_data);
        end
      end else if (mcount(oc) < 16) begin
        m_has[oc][r] = 1; m_ridx[oc][r] = int'(out_idx); m_rdat[oc][r] = int'(out_data);
      end
    end
    if (e_acc) begin
      m_eidx[ec] = int'(exit_idx); m_exp[ec] = int'(exit_count);
      for (int r = 0; r < 32; r++)
        if (m_has[ec][r] && m_ridx[ec][r] > int'(exit_idx)) m_has[ec][r] = 0;
    end
    if (m_drain) begin
      int r = mmin(h);
      if (r >= 0) m_has[h][r] = 0;
      else begin m_valid[h] = 0; m_head = (h + 1) % 4; m_drain = 0; end
    end else if (go) m_drain = 1;
    if (fl) begin
      int de = (ec - h + 4) % 4;
      for (int k = 0; k < 4; k++) if ((k - h + 4) % 4 > de) m_valid[k] = 0;
      m_tail = (ec + 1) % 4;
    end
    if (a_acc) begin
      m_valid[m_tail] = 1; m_exp[m_tail] = int'(alloc_count); m_eidx[m_tail] = 63;
      for (int r = 0; r < 32; r++) m_has[m_tail][r] = 0;
      m_tail = (m_tail + 1) % 4;
    end
  endtask

  task automatic check(input bit ok, input string tag, input string what, input int act, input int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic compare(input string tag);
    int r = mmin(m_head);
    bit ewe = m_drain && r >= 0;
    bit full = m_valid[0] && m_valid[1] && m_valid[2] && m_valid[3];
    check(rf_we == ewe, tag, "rf_we", int'(rf_we), int'(ewe));
    if (ewe) begin
      check(int'(rf_addr) == r, tag, "rf_addr", int'(rf_addr), r);
      check(int'(rf_data) == m_rdat[m_head][r], tag, "rf_data", int'(rf_data), m_rdat[m_head][r]);
    end
    check(alloc_ready == !full, tag, "alloc_ready", int'(alloc_ready), int'(!full));
    check(int'(alloc_id) == m_tail, tag, "alloc_id", int'(alloc_id), m_tail);
  endtask

  task automatic clr();
    alloc_valid = 0; out_valid = 0; exit_valid = 0; out_pred = 0; exit_mis = 0;
  endtask

  task automatic tick(input string tag);
    @(posedge clk); model_step();
    @(negedge clk); compare(tag); clr();
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) tick(tag);
  endtask

  task automatic set_out(input int c, input int r, input int i, input int d, input bit p);
    out_valid = 1; out_ctx = 2'(c); out_reg = 5'(r); out_idx = 6'(i);
    out_data = 16'(d); out_pred = p;
  endtask

  task automatic set_exit(input int c, input int i, input int n, input bit mis);
    exit_valid = 1; exit_ctx = 2'(c); exit_idx = 6'(i); exit_count = 5'(n); exit_mis = mis;
  endtask

  task automatic put(input int c, input int r, input int i, input int d, input bit p, input string tag);
    set_out(c, r, i, d, p); tick(tag);
  endtask

  task automatic alloc(input int n, input string tag);
    alloc_valid = 1; alloc_count = 5'(n); tick(tag);
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    mismatched++;
    $display("FAIL R4 watchdog: actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    int c;
    for (int k = 0; k < 4; k++) begin m_valid[k] = 0; m_exp[k] = 0; m_eidx[k] = 63; end
    repeat (3) @(negedge clk);
    rst_ni = 1;
    compare("R1");
    idle(2, "R1");
    // R2: fill the ring, fifth request refused
    for (int k = 0; k < 5; k++) alloc(2, "R2");
    idle(2, "R2");
    // R3: disabled predicate counts for nothing
    put(0, 4, 1, 16'h1111, 0, "R3");
    // R6: younger block completes first and must wait
    put(1, 1, 2, 16'h0a01, 1, "R6");
    put(1, 2, 3, 16'h0a02, 1, "R6");
    idle(3, "R6");
    // R5: index order, not arrival order
    put(0, 7, 9, 16'h0b07, 1, "R5");
    put(0, 3, 4, 16'h0b03, 1, "R5");
    put(0, 4, 5, 16'h0bad, 1, "R3");  // arrives after completion
    idle(10, "R6");
    // R7: duplicates
    put(2, 5, 10, 16'h0c0a, 1, "R7");
    put(2, 5, 12, 16'h0c0c, 1, "R7");
    put(2, 5, 11, 16'h0c0b, 1, "R7");
    put(2, 6, 1, 16'h0c01, 1, "R7");
    idle(8, "R7");
    // R8: exit purge, window, same-cycle collision
    put(3, 8, 30, 16'h0d08, 1, "R8");
    set_exit(3, 20, 2, 0); set_out(3, 11, 5, 16'h0d0b, 1); tick("R8");
    put(3, 9, 25, 16'h0d19, 1, "R8");
    put(3, 9, 15, 16'h0d09, 1, "R8");
    put(3, 10, 3, 16'h0d0a, 1, "R8");
    idle(8, "R8");
    // R9: mispredict flush beats allocation
    for (int k = 0; k < 3; k++) alloc(3, "R9");
    c = m_head;
    set_exit(c, 63, 3, 1); alloc_valid = 1; alloc_count = 1; tick("R9");
    put((c + 1) % 4, 12, 2, 16'h0e00, 1, "R3");
    put(c, 12, 2, 16'h0e0c, 1, "R9");
    put(c, 13, 2, 16'h0e0d, 1, "R9");
    put(c, 14, 0, 16'h0e0e, 1, "R9");
    idle(8, "R9");
    // R11: empty blocks
    alloc(0, "R11");
    alloc(0, "R11");
    idle(6, "R11");
    // R10: capacity
    c = m_tail;
    alloc(20, "R10");
    for (int k = 0; k < 18; k++) put(c, k, 40 - k, 16'h1000 + k, 1, "R10");
    set_exit(c, 63, 16, 0); tick("R10");
    idle(24, "R10");
    // random mix
    for (int n = 0; n < 4000; n++) begin
      if ($urandom_range(99) < 20) begin alloc_valid = 1; alloc_count = 5'($urandom_range(4)); end
      if ($urandom_range(99) < 70)
        set_out($urandom_range(3), $urandom_range(7), $urandom_range(63),
                $urandom_range(65535), $urandom_range(9) != 0);
      if ($urandom_range(99) < 4)
        set_exit($urandom_range(3), $urandom_range(63), $urandom_range(3), $urandom_range(1));
      tick("R4");
    end
    summary();
    $finish;
  end
endmodule